// File: doc/BRIEF.md
# Potentiometer Control Bus Slave

This block is the serial-bus slave that sits in front of a digitally controlled potentiometer. It watches a two-wire bus (SCL and SDA) that it samples with the system clock. On that bus it recognises start and stop conditions and accepts frames that carry its own address. It decodes a one-byte command and then does one of four things. It may finish right after the command, take one data byte from the master, send one data byte back, or enter a stepping mode in which every further SCL pulse moves the wiper by one position.

Nothing on the bus is stored here. The block emits single-cycle strobes, a register select and write data toward the wiper register and the four-entry register bank that sit beside it. For reads it takes their current contents back in. SDA is driven only through an open-drain pull-down enable. While the bank reports a nonvolatile write in progress, the slave does not acknowledge its own address, so a host can poll until the write is done.

Top module: `dpot_bus_slave`

## Requirements
- R1: A falling SDA while SCL is high (start) restarts address reception from any state, including mid-frame. A rising SDA while SCL is high (stop) returns the slave to idle, and after a stop no byte is acknowledged until a new start.
- R2: The address byte must be 0101 in bits 7..4, then pin A3 in bit 3, pin A2 in bit 2, 0 in bit 1 and pin A0 in bit 0 (pins given as addr_pins_i = {A3, A2, A0}). On a match the slave pulls SDA low for the ninth clock. On a mismatch it never drives SDA for the rest of the frame.
- R3: While nv_busy_i is high during the address byte, the address is not acknowledged. Once nv_busy_i is low, the same address is acknowledged.
- R4: The command byte holds an opcode in bits 7..4 and a register select in bits 3..2, and bits 1..0 must be 0. The accepted opcodes are 1001 read wiper, 1010 write wiper, 1011 read register, 1100 write register, 1101 register to wiper, 1110 wiper to register and 0010 step mode. Any other opcode, or nonzero bits 1..0, gets no acknowledge and sends the slave to idle.
- R5: After write wiper, the third byte is acknowledged. When its acknowledge clock ends, wiper_load_o pulses for one cycle with wr_data_o equal to bits 5..0 of that byte.
- R6: After write register, the third byte is acknowledged. When its acknowledge clock ends, dreg_load_o pulses with reg_sel_o equal to the select from the command and wr_data_o equal to bits 5..0.
- R7: For read wiper and read register, the slave sends 00 followed by the 6-bit value, MSB first. It changes its pull-down only while SCL is low, and it releases SDA during the master's acknowledge clock.
- R8: The two transfer commands raise their strobe (xfer_to_wiper_o or xfer_to_dreg_o, with reg_sel_o set) when the command acknowledge clock ends. No further byte in that frame is acknowledged.
- R9: In step mode, each SCL high pulse gives one step_o pulse as SCL falls, with step_up_o equal to the SDA level seen while SCL was high (1 = up). A stop ends the mode without producing a step.
- R10: Each strobe lasts one cycle, and at most one of the five strobes is high in any cycle.
- R11: During and right after reset, SDA is released and no strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| addr_pins_i | input | 3 | Strapped address bits {A3, A2, A0} |
| nv_busy_i | input | 1 | Nonvolatile write in progress in the register bank |
| wiper_val_i | input | VAL_W | Current wiper register value, for reads |
| dreg_val_i | input | VAL_W | Bank entry selected by reg_sel_o, for reads |
| sda_pd_o | output | 1 | Open-drain pull-down enable for SDA |
| reg_sel_o | output | 2 | Bank entry selected by the last command |
| wr_data_o | output | VAL_W | Data for wiper or bank writes |
| wiper_load_o | output | 1 | Load wr_data_o into the wiper |
| dreg_load_o | output | 1 | Load wr_data_o into the selected bank entry |
| xfer_to_wiper_o | output | 1 | Copy the selected bank entry into the wiper |
| xfer_to_dreg_o | output | 1 | Copy the wiper into the selected bank entry |
| step_o | output | 1 | Move the wiper by one position |
| step_up_o | output | 1 | Direction for step_o (1 = up) |

## Verification
The bench uses the default build of two synchroniser stages and a 6-bit value, with the address pins strapped to 101. Each SCL phase lasts ten system clocks, which leaves enough slack for the synchroniser latency. That slack makes the ordering between a detected SCL edge and the slave's own SDA change observable. With a 6-bit value, the two zero pad bits of every read byte become visible. Saturation at both ends of the wiper range can be reached in a few step pulses, and all four bank entries are addressable, so select decoding can be checked against distinct stored values.

// File: rtl/dpot_bus_pkg.sv
package dpot_bus_pkg;

    localparam logic [3:0] DEV_TYPE    = 4'b0101;

    localparam logic [3:0] OP_RD_WIPER = 4'b1001;
    localparam logic [3:0] OP_WR_WIPER = 4'b1010;
    localparam logic [3:0] OP_RD_DREG  = 4'b1011;
    localparam logic [3:0] OP_WR_DREG  = 4'b1100;
    localparam logic [3:0] OP_XFER_D2W = 4'b1101;
    localparam logic [3:0] OP_XFER_W2D = 4'b1110;
    localparam logic [3:0] OP_STEP     = 4'b0010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_INSTR,
        ST_INSTR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_MACK,
        ST_STEP,
        ST_HOLD
    } fsm_e;

    function automatic logic op_known(input logic [3:0] op);
        case (op)
            OP_RD_WIPER, OP_WR_WIPER, OP_RD_DREG, OP_WR_DREG,
            OP_XFER_D2W, OP_XFER_W2D, OP_STEP: return 1'b1;
            default:                           return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/dpot_line_cond.sv
module dpot_line_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);

    localparam int TOP = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] scl_sh;
        logic [SYNC_STAGES-1:0] sda_sh;
        logic                   scl_prev;
        logic                   sda_prev;
    } line_st_t;

    line_st_t q, d;
    logic [SYNC_STAGES-1:0] scl_nxt, sda_nxt;

    generate
        if (SYNC_STAGES == 1) begin : g_single
            assign scl_nxt = scl_i;
            assign sda_nxt = sda_i;
        end else begin : g_chain
            assign scl_nxt = {q.scl_sh[SYNC_STAGES-2:0], scl_i};
            assign sda_nxt = {q.sda_sh[SYNC_STAGES-2:0], sda_i};
        end
    endgenerate

    always_comb begin
        d          = q;
        d.scl_sh   = scl_nxt;
        d.sda_sh   = sda_nxt;
        d.scl_prev = q.scl_sh[TOP];
        d.sda_prev = q.sda_sh[TOP];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign scl_lvl   = q.scl_sh[TOP];
    assign sda_lvl   = q.sda_sh[TOP];
    assign scl_rise  = scl_lvl & ~q.scl_prev;
    assign scl_fall  = ~scl_lvl & q.scl_prev;
    assign start_evt = scl_lvl & q.scl_prev & q.sda_prev & ~sda_lvl;
    assign stop_evt  = scl_lvl & q.scl_prev & ~q.sda_prev & sda_lvl;

endmodule

// File: rtl/dpot_cmd_fsm.sv
module dpot_cmd_fsm
    import dpot_bus_pkg::*;
#(
    parameter int VAL_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_lvl,
    input  logic             sda_lvl,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_evt,
    input  logic             stop_evt,
    input  logic [2:0]       addr_pins,
    input  logic             nv_busy,
    input  logic [VAL_W-1:0] wiper_val,
    input  logic [VAL_W-1:0] dreg_val,
    output logic             sda_pd,
    output logic [1:0]       reg_sel,
    output logic [VAL_W-1:0] wr_data,
    output logic             wiper_load,
    output logic             dreg_load,
    output logic             xfer_to_wiper,
    output logic             xfer_to_dreg,
    output logic             step,
    output logic             step_up
);

    localparam logic [3:0] BITS_PER_BYTE = 4'd8;

    typedef struct packed {
        fsm_e             state;
        logic [3:0]       cnt;
        logic [7:0]       sh;
        logic [3:0]       op;
        logic [1:0]       sel;
        logic             pd;
        logic             dir;
        logic [VAL_W-1:0] wdata;
        logic             wiper_ld;
        logic             dreg_ld;
        logic             x_d2w;
        logic             x_w2d;
        logic             step;
    } fsm_st_t;

    fsm_st_t q, d;
    logic       addr_hit;
    logic [7:0] rd_byte;

    assign addr_hit = (q.sh[7:4] == DEV_TYPE) && (q.sh[3] == addr_pins[2]) &&
                      (q.sh[2] == addr_pins[1]) && !q.sh[1] &&
                      (q.sh[0] == addr_pins[0]);
    assign rd_byte  = (q.op == OP_RD_WIPER) ? 8'(wiper_val) : 8'(dreg_val);

    always_comb begin
        d          = q;
        d.wiper_ld = 1'b0;
        d.dreg_ld  = 1'b0;
        d.x_d2w    = 1'b0;
        d.x_w2d    = 1'b0;
        d.step     = 1'b0;
        if (start_evt) begin
            d.state = ST_ADDR;
            d.cnt   = '0;
            d.pd    = 1'b0;
        end else if (stop_evt) begin
            d.state = ST_IDLE;
            d.pd    = 1'b0;
        end else begin
            case (q.state)
                ST_ADDR, ST_INSTR, ST_WDATA: begin
                    if (scl_rise && (q.cnt < BITS_PER_BYTE)) begin
                        d.sh  = {q.sh[6:0], sda_lvl};
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall && (q.cnt == BITS_PER_BYTE)) begin
                        case (q.state)
                            ST_ADDR: begin
                                if (addr_hit && !nv_busy) begin
                                    d.state = ST_ADDR_ACK;
                                    d.pd    = 1'b1;
                                end else begin
                                    d.state = ST_IDLE;
                                end
                            end
                            ST_INSTR: begin
                                if (op_known(q.sh[7:4]) && (q.sh[1:0] == 2'b00)) begin
                                    d.op    = q.sh[7:4];
                                    d.sel   = q.sh[3:2];
                                    d.state = ST_INSTR_ACK;
                                    d.pd    = 1'b1;
                                end else begin
                                    d.state = ST_IDLE;
                                end
                            end
                            default: begin
                                d.wdata = q.sh[VAL_W-1:0];
                                d.state = ST_WDATA_ACK;
                                d.pd    = 1'b1;
                            end
                        endcase
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        d.pd    = 1'b0;
                        d.cnt   = '0;
                        d.state = ST_INSTR;
                    end
                end
                ST_INSTR_ACK: begin
                    if (scl_fall) begin
                        d.pd  = 1'b0;
                        d.cnt = '0;
                        case (q.op)
                            OP_RD_WIPER, OP_RD_DREG: begin
                                d.sh    = rd_byte;
                                d.pd    = ~rd_byte[7];
                                d.state = ST_RDATA;
                            end
                            OP_WR_WIPER, OP_WR_DREG: d.state = ST_WDATA;
                            OP_XFER_D2W: begin
                                d.x_d2w = 1'b1;
                                d.state = ST_HOLD;
                            end
                            OP_XFER_W2D: begin
                                d.x_w2d = 1'b1;
                                d.state = ST_HOLD;
                            end
                            OP_STEP: d.state = ST_STEP;
                            default: d.state = ST_IDLE;
                        endcase
                    end
                end
                ST_WDATA_ACK: begin
                    if (scl_fall) begin
                        d.pd       = 1'b0;
                        d.wiper_ld = (q.op == OP_WR_WIPER);
                        d.dreg_ld  = (q.op == OP_WR_DREG);
                        d.state    = ST_HOLD;
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        d.sh  = {q.sh[6:0], 1'b0};
                        d.cnt = q.cnt + 4'd1;
                        if (q.cnt == BITS_PER_BYTE - 4'd1) begin
                            d.state = ST_MACK;
                            d.pd    = 1'b0;
                        end else begin
                            d.pd = ~q.sh[6];
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_fall) d.state = ST_HOLD;
                end
                ST_STEP: begin
                    if (scl_rise) d.dir  = sda_lvl;
                    if (scl_fall) d.step = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sda_pd        = q.pd;
    assign reg_sel       = q.sel;
    assign wr_data       = q.wdata;
    assign wiper_load    = q.wiper_ld;
    assign dreg_load     = q.dreg_ld;
    assign xfer_to_wiper = q.x_d2w;
    assign xfer_to_dreg  = q.x_w2d;
    assign step          = q.step;
    assign step_up       = q.dir;

    AST_PD_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((sda_pd != $past(sda_pd)) && !$past(start_evt) && !$past(stop_evt)) |-> !$past(scl_lvl)); // R7
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wiper_load, dreg_load, xfer_to_wiper, xfer_to_dreg, step})); // R10
    AST_STEP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> !step); // R10
    AST_BUSY_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.state == ST_ADDR_ACK) && ($past(q.state) == ST_ADDR)) |-> !$past(nv_busy)); // R3
    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(stop_evt) && !$past(start_evt)) |-> (q.state == ST_IDLE)); // R1
    AST_STEP_IN_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> ($past(q.state) == ST_STEP)); // R9
    AST_XFER_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_to_wiper || xfer_to_dreg) |-> ($past(q.state) == ST_INSTR_ACK)); // R8

endmodule

// File: rtl/dpot_bus_slave.sv
module dpot_bus_slave #(
    parameter int SYNC_STAGES = 2,
    parameter int VAL_W       = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic [2:0]       addr_pins_i,
    input  logic             nv_busy_i,
    input  logic [VAL_W-1:0] wiper_val_i,
    input  logic [VAL_W-1:0] dreg_val_i,
    output logic             sda_pd_o,
    output logic [1:0]       reg_sel_o,
    output logic [VAL_W-1:0] wr_data_o,
    output logic             wiper_load_o,
    output logic             dreg_load_o,
    output logic             xfer_to_wiper_o,
    output logic             xfer_to_dreg_o,
    output logic             step_o,
    output logic             step_up_o
);

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;

    dpot_line_cond #(.SYNC_STAGES(SYNC_STAGES)) u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    dpot_cmd_fsm #(.VAL_W(VAL_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_lvl       (scl_lvl),
        .sda_lvl       (sda_lvl),
        .scl_rise      (scl_rise),
        .scl_fall      (scl_fall),
        .start_evt     (start_evt),
        .stop_evt      (stop_evt),
        .addr_pins     (addr_pins_i),
        .nv_busy       (nv_busy_i),
        .wiper_val     (wiper_val_i),
        .dreg_val      (dreg_val_i),
        .sda_pd        (sda_pd_o),
        .reg_sel       (reg_sel_o),
        .wr_data       (wr_data_o),
        .wiper_load    (wiper_load_o),
        .dreg_load     (dreg_load_o),
        .xfer_to_wiper (xfer_to_wiper_o),
        .xfer_to_dreg  (xfer_to_dreg_o),
        .step          (step_o),
        .step_up       (step_up_o)
    );

endmodule

// File: tb/dpot_bus_slave_tb.sv
module dpot_bus_slave_tb;

    localparam int Q = 10;
    localparam logic [7:0] ADDR_OK  = 8'h59;
    localparam logic [7:0] ADDR_BAD = 8'h51;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       busy  = 1'b0;
    logic [2:0] pins  = 3'b101;
    logic [5:0] wiper;
    logic [5:0] dr [4];
    logic       sda_line;
    logic       sda_pd, step_up;
    logic [1:0] reg_sel;
    logic [5:0] wr_data;
    logic       wiper_load, dreg_load, x_d2w, x_w2d, step;

    assign sda_line = m_sda & ~sda_pd;

    dpot_bus_slave u_dut (
        .clk (clk), .rst_n (rst_n), .scl_i (m_scl), .sda_i (sda_line),
        .addr_pins_i (pins), .nv_busy_i (busy),
        .wiper_val_i (wiper), .dreg_val_i (dr[reg_sel]),
        .sda_pd_o (sda_pd), .reg_sel_o (reg_sel), .wr_data_o (wr_data),
        .wiper_load_o (wiper_load), .dreg_load_o (dreg_load),
        .xfer_to_wiper_o (x_d2w), .xfer_to_dreg_o (x_w2d),
        .step_o (step), .step_up_o (step_up)
    );

    // register bank model and strobe monitors
    int up_cnt, dn_cnt, strb_bad;
    logic [4:0] strb, strb_prev;
    assign strb = {wiper_load, dreg_load, x_d2w, x_w2d, step};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wiper <= '0;
            for (int i = 0; i < 4; i++) dr[i] <= '0;
            up_cnt <= 0; dn_cnt <= 0; strb_bad <= 0; strb_prev <= '0;
        end else begin
            strb_prev <= strb;
            if (($countones(strb) > 1) || ((strb & strb_prev) != 0)) strb_bad <= strb_bad + 1;
            if (wiper_load) wiper <= wr_data;
            if (dreg_load)  dr[reg_sel] <= wr_data;
            if (x_d2w)      wiper <= dr[reg_sel];
            if (x_w2d)      dr[reg_sel] <= wiper;
            if (step && step_up) begin
                up_cnt <= up_cnt + 1;
                if (wiper != 6'h3F) wiper <= wiper + 6'd1;
            end
            if (step && !step_up) begin
                dn_cnt <= dn_cnt + 1;
                if (wiper != 6'h00) wiper <= wiper - 6'd1;
            end
        end
    end

    int vecs = 0;
    int fails = 0;

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        vecs++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_start;
        if (!m_scl) begin
            wt(3); m_sda = 1'b1; wt(Q); m_scl = 1'b1; wt(Q);
        end
        m_sda = 1'b0; wt(Q); m_scl = 1'b0;
    endtask

    task automatic bus_stop;
        wt(3); m_sda = 1'b0; wt(Q); m_scl = 1'b1; wt(Q); m_sda = 1'b1; wt(Q);
    endtask

    task automatic clk_bit(input logic b, output logic seen);
        wt(3); m_sda = b; wt(Q);
        m_scl = 1'b1; wt(Q / 2);
        seen = sda_line; wt(Q / 2);
        m_scl = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(v[i], s);
        clk_bit(1'b1, s);
        ack = !s;
    endtask

    task automatic recv_byte(input logic master_ack, output logic [7:0] v, output logic line_in_ack);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            v[i] = s;
        end
        clk_bit(!master_ack, s);
        line_in_ack = s;
    endtask

    task automatic write3(input logic [7:0] cmd, input logic [7:0] val, input string req);
        logic a1, a2, a3;
        bus_start;
        send_byte(ADDR_OK, a1);
        send_byte(cmd, a2);
        send_byte(val, a3);
        bus_stop;
        wt(4);
        chk(a1 && a2 && a3, req, {a1, a2, a3}, 7);
    endtask

    task automatic read3(input logic [7:0] cmd, input logic [7:0] exp, input string req);
        logic a1, a2, rel;
        logic [7:0] v;
        bus_start;
        send_byte(ADDR_OK, a1);
        send_byte(cmd, a2);
        recv_byte(1'b0, v, rel);
        bus_stop;
        chk(a1 && a2, req, {a1, a2}, 3);
        chk(v == exp, req, v, exp);
        chk(rel == 1'b1, {req, " release in master ack"}, rel, 1);
    endtask

    task automatic t_reset;
        chk(sda_pd == 1'b0, "R11 pd in reset", sda_pd, 0);
        chk(strb == '0, "R11 strobes in reset", strb, 0);
        rst_n = 1'b1;
        wt(5);
        chk(sda_pd == 1'b0 && strb == '0, "R11 after reset", {sda_pd, strb}, 0);
    endtask

    task automatic t_addr;
        logic a1, a2;
        bus_start;
        send_byte(ADDR_BAD, a1);
        send_byte(8'hA0, a2);
        bus_stop;
        chk(!a1, "R2 mismatch no ack", a1, 0);
        chk(!a2, "R2 silent after mismatch", a2, 0);
    endtask

    task automatic t_write_read;
        write3(8'hA0, 8'h25, "R5 write wiper acks");
        chk(wiper == 6'h25, "R5 wiper value", wiper, 'h25);
        read3(8'h90, 8'h25, "R7 read wiper");
        write3(8'hC8, 8'h11, "R6 write reg acks");
        chk(dr[2] == 6'h11, "R6 reg 2 value", dr[2], 'h11);
        chk(wiper == 6'h25, "R6 wiper untouched", wiper, 'h25);
        write3(8'hC4, 8'h2A, "R6 write reg 1 acks");
        read3(8'hB8, 8'h11, "R7 read reg 2");
        read3(8'hB4, 8'h2A, "R7 read reg 1");
    endtask

    task automatic t_xfer;
        logic a1, a2, a3;
        bus_start;
        send_byte(ADDR_OK, a1);
        send_byte(8'hD8, a2);
        send_byte(8'hFF, a3);
        bus_stop;
        wt(4);
        chk(a1 && a2, "R8 transfer acks", {a1, a2}, 3);
        chk(!a3, "R8 no third ack", a3, 0);
        chk(wiper == 6'h11, "R8 reg to wiper", wiper, 'h11);
        write3(8'hA0, 8'h3E, "R8 setup wiper");
        bus_start;
        send_byte(ADDR_OK, a1);
        send_byte(8'hEC, a2);
        bus_stop;
        wt(4);
        chk(dr[3] == 6'h3E, "R8 wiper to reg 3", dr[3], 'h3E);
    endtask

    task automatic t_step;
        logic a1, a2, s;
        int u0, d0;
        u0 = up_cnt; d0 = dn_cnt;
        bus_start;
        send_byte(ADDR_OK, a1);
        send_byte(8'h20, a2);
        clk_bit(1'b1, s); clk_bit(1'b1, s); clk_bit(1'b1, s);
        clk_bit(1'b0, s);
        bus_stop;
        wt(4);
        chk(a1 && a2, "R9 step mode acks", {a1, a2}, 3);
        chk(up_cnt - u0 == 3, "R9 up steps", up_cnt - u0, 3);
        chk(dn_cnt - d0 == 1, "R9 down steps, none at stop", dn_cnt - d0, 1);
        read3(8'h90, 8'h3E, "R9 wiper after steps");
    endtask

    task automatic t_busy;
        logic a1;
        busy = 1'b1;
        bus_start; send_byte(ADDR_OK, a1); bus_stop;
        chk(!a1, "R3 busy no ack", a1, 0);
        busy = 1'b0;
        bus_start; send_byte(ADDR_OK, a1); bus_stop;
        chk(a1, "R3 ack once idle", a1, 1);
    endtask

    task automatic t_bad_op;
        logic a1, a2, a3;
        bus_start; send_byte(ADDR_OK, a1); send_byte(8'h70, a2); send_byte(8'h05, a3); bus_stop;
        chk(a1 && !a2 && !a3, "R4 unknown opcode", {a1, a2, a3}, 4);
        bus_start; send_byte(ADDR_OK, a1); send_byte(8'hA1, a2); bus_stop;
        chk(a1 && !a2, "R4 nonzero low bits", {a1, a2}, 2);
        chk(wiper == 6'h3E, "R4 wiper untouched", wiper, 'h3E);
    endtask

    task automatic t_restart;
        logic a1, a2, a3, s;
        bus_start;
        send_byte(ADDR_OK, a1);
        send_byte(8'hA0, a2);
        clk_bit(1'b1, s); clk_bit(1'b0, s); clk_bit(1'b1, s);
        bus_start;
        send_byte(ADDR_OK, a1);
        send_byte(8'hA0, a2);
        send_byte(8'h07, a3);
        bus_stop;
        wt(4);
        chk(a1 && a2 && a3, "R1 acks after restart", {a1, a2, a3}, 7);
        chk(wiper == 6'h07, "R1 wiper after restart", wiper, 7);
        bus_start;
        send_byte(ADDR_OK, a1);
        bus_stop;
        m_scl = 1'b0; wt(Q);
        send_byte(ADDR_OK, a2);
        bus_stop;
        chk(a1 && !a2, "R1 no ack after stop", {a1, a2}, 2);
    endtask

    initial begin
        wt(5);
        t_reset;
        t_addr;
        t_write_read;
        t_xfer;
        t_step;
        t_busy;
        t_bad_op;
        t_restart;
        wt(4);
        chk(strb_bad == 0, "R10 strobe exclusivity", strb_bad, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        vecs++;
        fails++;
        $display("FAIL watchdog R1 actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

endmodule